// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block keeps the microprogram address register of a microcoded control unit and works out the next control-store address every clock. The current microinstruction supplies a two-bit sequencing mode, two candidate target addresses, a flag selector and a polarity bit. The control unit supplies four CPU status flags and the opcode of the machine instruction just loaded. From these the block picks one of four next addresses: the following word, a fixed target, one of two targets chosen by a flag test, or the start of the routine for the opcode.

The address register is updated only on the rising clock edge. Its value drives the control-memory address port directly. Choosing the next address is pure combinational logic working on this cycle's inputs. The opcode-to-routine map is a lookup table whose contents are fixed by a parameter at elaboration time.

Top module: `useq_top`

## Requirements
- R1: A synchronous active-high reset sets the address output to 0 on the next rising edge, whatever the other inputs are.
- R2: With mode 2'b00 the address becomes the current address plus one, modulo 2**AW (255 wraps to 0).
- R3: With mode 2'b01 the address becomes the target-A input unchanged, and the flags have no effect on it.
- R4: With mode 2'b10 the address becomes target A when the tested condition is true and target B when it is false.
- R5: The flag selector chooses a flag from the flag vector {V,C,N,Z} = flags[3:0]: 0 selects Z (bit 0), 1 selects N (bit 1), 2 selects C (bit 2), 3 selects V (bit 3).
- R6: With the polarity bit at 0 the condition is true when the selected flag is 1. With the polarity bit at 1 the condition is true when the selected flag is 0.
- R7: With mode 2'b11 the address becomes the map entry for the 4-bit opcode. Entry k sits at bits [8k+7:8k] of the parameter OPMAP.
- R8: The address changes only at a rising clock edge. It holds its value between edges even when the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_mode | input | 2 | Sequencing mode: 00 increment, 01 jump, 10 conditional, 11 dispatch |
| tgt_a | input | 8 | Jump target, or conditional target taken when the condition is true |
| tgt_b | input | 8 | Conditional target taken when the condition is false |
| flag_sel | input | 2 | Selects the flag to test: 0 Z, 1 N, 2 C, 3 V |
| test_clear | input | 1 | When 1, the test is true if the selected flag is 0 |
| flags | input | 4 | Status flags {V,C,N,Z} |
| opcode | input | 4 | Opcode of the machine instruction just loaded |
| car | output | 8 | Control address register, drives the control-memory address |

## Verification
On every cycle, assertions check these behaviours: the reset value, the increment with wrap-around, the plain jump, the conditional outcome recomputed from the flag inputs, and the dispatch result against the parameter map. Several things only the bench scenarios can show. One is that each flag selector is wired to its own flag bit with the intended polarity. This needs patterns in which the selected flag and the other flags disagree. Another is that the address register holds between edges while the inputs move, which the bench shows by sampling mid-cycle after changing inputs.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [1:0] {
    SEQ_INC  = 2'b00,
    SEQ_JMP  = 2'b01,
    SEQ_COND = 2'b10,
    SEQ_DISP = 2'b11
  } seq_mode_e;

  typedef enum logic [1:0] {
    FLG_Z = 2'd0,
    FLG_N = 2'd1,
    FLG_C = 2'd2,
    FLG_V = 2'd3
  } flag_sel_e;
endpackage

// File: rtl/useq_cond.sv
module useq_cond #(
  parameter int NFLAG = 4,
  localparam int SW = $clog2(NFLAG)
) (
  input  logic [NFLAG-1:0] flags,
  input  logic [SW-1:0]    sel,
  input  logic             invert,
  output logic             cond_true
);
  logic picked;
  always_comb begin
    picked    = flags[sel];
    cond_true = picked ^ invert;
  end
endmodule

// File: rtl/useq_map.sv
module useq_map #(
  parameter int AW = 8,
  parameter int OW = 4,
  localparam int NENT = 1 << OW,
  parameter logic [NENT*AW-1:0] OPMAP = '0
) (
  input  logic [OW-1:0] opcode,
  output logic [AW-1:0] start_addr
);
  logic [AW-1:0] table_q [NENT];
  for (genvar k = 0; k < NENT; k++) begin : g_ent
    assign table_q[k] = OPMAP[k*AW +: AW];
  end
  assign start_addr = table_q[opcode];
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int AW = 8,
  parameter int OW = 4,
  parameter int NFLAG = 4,
  localparam int NENT = 1 << OW,
  localparam int SW = $clog2(NFLAG),
  parameter logic [NENT*AW-1:0] OPMAP = {
    8'hF0, 8'hE0, 8'hD0, 8'hC0, 8'hB0, 8'hA0, 8'h90, 8'h80,
    8'h70, 8'h60, 8'h50, 8'h40, 8'h30, 8'h20, 8'h10, 8'h08}
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      seq_mode,
  input  logic [AW-1:0]   tgt_a,
  input  logic [AW-1:0]   tgt_b,
  input  logic [SW-1:0]   flag_sel,
  input  logic            test_clear,
  input  logic [NFLAG-1:0] flags,
  input  logic [OW-1:0]   opcode,
  output logic [AW-1:0]   car
);
  logic          cond_true;
  logic [AW-1:0] disp_addr;
  logic [AW-1:0] next_addr;
  logic [AW-1:0] car_q;

  useq_cond #(.NFLAG(NFLAG)) u_cond (
    .flags(flags), .sel(flag_sel), .invert(test_clear), .cond_true(cond_true));

  useq_map #(.AW(AW), .OW(OW), .OPMAP(OPMAP)) u_map (
    .opcode(opcode), .start_addr(disp_addr));

  always_comb begin
    unique case (seq_mode_e'(seq_mode))
      SEQ_INC:  next_addr = car_q + AW'(1);
      SEQ_JMP:  next_addr = tgt_a;
      SEQ_COND: next_addr = cond_true ? tgt_a : tgt_b;
      SEQ_DISP: next_addr = disp_addr;
      default:  next_addr = car_q + AW'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) car_q <= '0;
    else     car_q <= next_addr;
  end

  assign car = car_q;

  logic past_ok;
  always_ff @(posedge clk) past_ok <= 1'b1;

  assert_reset_zero_R1: assert property (@(posedge clk)
    past_ok && $past(rst) |-> car == '0);
  assert_inc_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(rst) && $past(seq_mode) == 2'b00 |-> car == AW'($past(car) + 1));
  assert_jump_R3: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(rst) && $past(seq_mode) == 2'b01 |-> car == $past(tgt_a));
  assert_cond_R4: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(rst) && $past(seq_mode) == 2'b10 |->
      car == ((($past(flags) >> $past(flag_sel)) & 1) != {{(NFLAG-1){1'b0}}, $past(test_clear)}
              ? $past(tgt_a) : $past(tgt_b)));
  assert_dispatch_R7: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(rst) && $past(seq_mode) == 2'b11 |->
      car == AW'(OPMAP >> ($past(opcode) * AW)));
endmodule

// File: tb/useq_top_test.sv
`timescale 1ns/1ps
module useq_top_test;
  logic clk = 0;
  logic rst;
  logic [1:0] seq_mode;
  logic [7:0] tgt_a, tgt_b;
  logic [1:0] flag_sel;
  logic test_clear;
  logic [3:0] flags;
  logic [3:0] opcode;
  logic [7:0] car;

  int n_cmp = 0, n_bad = 0;
  int model;
  bit done = 0;

  always #5 clk = ~clk;

  useq_top uut (.clk(clk), .rst(rst), .seq_mode(seq_mode), .tgt_a(tgt_a), .tgt_b(tgt_b),
    .flag_sel(flag_sel), .test_clear(test_clear), .flags(flags), .opcode(opcode), .car(car));

  function automatic int map_of(int op);
    return (op == 0) ? 8 : op * 16;
  endfunction

  function automatic int predict(int cur, bit r, int m, int a, int b, int s, bit inv, int f, int op);
    bit fl;
    if (r) return 0;
    case (m)
      0: return (cur + 1) % 256;
      1: return a;
      2: begin
        fl = (f >> s) & 1;
        return ((fl != inv) ? a : b);
      end
      default: return map_of(op);
    endcase
  endfunction

  task automatic check(string req, int exp);
    n_cmp++;
    if (car !== 8'(exp)) begin
      n_bad++;
      $display("FAIL %s: car=%0d expected=%0d", req, car, exp);
    end
  endtask

  // apply inputs at mid-low phase, clock once, compare at negedge
  task automatic step(string req, bit r, int m, int a, int b, int s, bit inv, int f, int op);
    rst = r; seq_mode = 2'(m); tgt_a = 8'(a); tgt_b = 8'(b);
    flag_sel = 2'(s); test_clear = inv; flags = 4'(f); opcode = 4'(op);
    model = predict(model, r, m, a, b, s, inv, f, op);
    @(posedge clk); @(negedge clk);
    check(req, model);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: car=%0d expected=finish", car);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    model = 0;
    @(negedge clk);
    step("R1", 1, 2, 77, 88, 0, 0, 15, 5);
    // R2 increment several times
    for (int i = 0; i < 5; i++) step("R2", 0, 0, 0, 0, 0, 0, 0, 0);
    // R3 jump, flags varied
    step("R3", 0, 1, 200, 3, 0, 0, 15, 0);
    step("R3", 0, 1, 254, 9, 1, 1, 0, 0);
    // R2 wrap 254->255->0->1
    step("R2", 0, 0, 0, 0, 0, 0, 0, 0);
    step("R2", 0, 0, 0, 0, 0, 0, 0, 0);
    step("R2", 0, 0, 0, 0, 0, 0, 0, 0);
    // R4 R5 R6: each selector, both polarities, flag set and clear, others opposite
    for (int s = 0; s < 4; s++)
      for (int inv = 0; inv < 2; inv++) begin
        step("R5", 0, 2, 16 + s, 32 + s, s, inv[0], 1 << s, 0);
        step("R6", 0, 2, 64 + s, 96 + s, s, inv[0], 15 & ~(1 << s), 0);
        step("R4", 0, 2, 128 + s, 160 + s, s, inv[0], (inv != 0) ? 0 : 15, 0);
      end
    // R7 dispatch every opcode
    for (int op = 0; op < 16; op++) step("R7", 0, 3, 1, 2, 0, 0, 0, op);
    // R8 hold between edges while inputs wiggle
    step("R3", 0, 1, 42, 0, 0, 0, 0, 0);
    #1; seq_mode = 2'b01; tgt_a = 8'd99; opcode = 4'd7; #2;
    check("R8", model);
    @(posedge clk); #1 seq_mode = 2'b11; opcode = 4'd3; #2;
    model = 99;
    check("R8", model);
    @(negedge clk);
    // reset mid-run overrides mode
    step("R1", 1, 1, 123, 0, 0, 0, 0, 0);
    step("R2", 0, 0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule